// File: doc/BRIEF.md
# Parallel Box-Pair Overlap Sweeper

This block holds an axis-aligned bounding box for each of up to 2^IDX_W objects and, once started, tests every unordered pair of the boxes with indices 0 through a programmed last index for overlap. Each box consists of a lower and an upper bound on each of the x, y and z axes. The bounds are IEEE-754 single-precision bit patterns. Every bound is written into BANKS identical dual-port memories, which gives the sweep 2·BANKS read ports per coordinate.

One read port always addresses the current anchor box. The other L = 2·BANKS−1 ports step through the anchor's partners. As a result, L pair tests complete in every cycle. When a partner address reaches the last index, the anchor moves forward by one and the partners restart just above it.

Each output lane reports a valid flag, an overlap flag and the partner index. The anchor index is shared by all lanes in a cycle. A one-cycle done pulse arrives together with the final group of results.

Top module: `box_pair_sweep`

## Requirements
- R1: A write with `wr_en` high while idle stores the six bounds of box `wr_idx` into every bank. Any read port can then return that box, so the results do not depend on which lane a box lands in.
- R2: A sweep with last index N reports every pair (i, j) with i < j ≤ N exactly once as a valid lane. The anchor is i and the partner is j. No other pair is reported valid.
- R3: Partner addresses advance in this order. The first result group has anchor 0 and partners 1..L on lanes 0..L−1. Within a group, lane k+1 carries the partner index one above lane k.
- R4: A lane whose partner address is above the last index is marked invalid.
- R5: A valid lane flags a hit exactly when all six inclusive tests hold: upper(i) ≥ lower(j) and lower(i) ≤ upper(j) on x, on y and on z. Touching faces count as a hit.
- R6: Bounds are ordered as real numbers. A negative value ranks below every positive value, and a larger magnitude ranks lower among negatives. +0.0 (0x00000000) and −0.0 (0x80000000) compare equal.
- R7: `done` is high for exactly one cycle, in the same cycle as the final result group. `busy` has already dropped by then. The lane outputs stay invalid while the block is idle.
- R8: `start` and writes are ignored while `busy` is high. The running sweep and the stored boxes are unchanged.
- R9: A sweep with last index 0 produces a `done` pulse and no valid lane.
- R10: A lane never flags a hit without being valid.
- R11: After reset, `busy`, `done` and all lane valid and hit flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Store a box (ignored while busy) |
| wr_idx | input | IDX_W | Box index being written |
| wr_xlo | input | 32 | Lower x bound, single-precision |
| wr_xhi | input | 32 | Upper x bound |
| wr_ylo | input | 32 | Lower y bound |
| wr_yhi | input | 32 | Upper y bound |
| wr_zlo | input | 32 | Lower z bound |
| wr_zhi | input | 32 | Upper z bound |
| cfg_last | input | IDX_W | Highest box index taking part, captured at start |
| start | input | 1 | Begin a sweep (ignored while busy) |
| busy | output | 1 | Read addresses are being issued |
| anchor_idx | output | IDX_W | Anchor index shared by all lanes this cycle |
| partner_idx | output | L*IDX_W | Partner index per lane, lane k at bits k*IDX_W |
| lane_vld | output | L | Lane carries a real pair |
| lane_hit | output | L | Pair overlaps on all three axes |
| done | output | 1 | One-cycle pulse with the final result group |

## Verification
Directed runs cover four kinds of box sets. The first is a set where every box overlaps every other, which shows whether each pair is visited exactly once. The second is a chain of boxes that touch only their neighbours, which separates the inclusive test from a strict one and exposes any bank that returns the wrong box. The third uses negative bounds and signed zeros to exercise the float ordering. The fourth is a random set over the full index range, compared against a pair-by-pair model. Further runs cover last indices 0 and 1, and a sweep disturbed by a start and a write while busy; the stored data and the count of visited pairs must then be unchanged.

// File: rtl/box_pair_sweep.sv
module box_pair_sweep #(
  parameter int BANKS = 2,
  parameter int IDX_W = 5,
  localparam int L = 2 * BANKS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_xlo,
  input  logic [31:0]      wr_xhi,
  input  logic [31:0]      wr_ylo,
  input  logic [31:0]      wr_yhi,
  input  logic [31:0]      wr_zlo,
  input  logic [31:0]      wr_zhi,
  input  logic [IDX_W-1:0] cfg_last,
  input  logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] anchor_idx,
  output logic [L*IDX_W-1:0] partner_idx,
  output logic [L-1:0]     lane_vld,
  output logic [L-1:0]     lane_hit,
  output logic             done
);
  localparam int PORTS = 2 * BANKS;
  localparam int DEPTH = 1 << IDX_W;
  localparam int AW    = IDX_W + $clog2(PORTS) + 1;

  function automatic logic [31:0] ord_key(input logic [31:0] f);
    if (f[30:0] == 31'd0) return 32'h8000_0000;
    return f[31] ? ~f : {1'b1, f[30:0]};
  endfunction

  logic [AW-1:0] anc, prt, last_q;
  logic [AW-1:0] s1_anc, s1_prt;
  logic          s1_act, s1_last;
  logic [AW-1:0] ra [PORTS];
  logic [31:0]   rq [6][PORTS];
  logic [31:0]   wr_w [6];
  logic          wr_ok;

  assign wr_ok   = wr_en && !busy;
  assign wr_w[0] = wr_xlo;
  assign wr_w[1] = wr_xhi;
  assign wr_w[2] = wr_ylo;
  assign wr_w[3] = wr_yhi;
  assign wr_w[4] = wr_zlo;
  assign wr_w[5] = wr_zhi;

  wire [AW-1:0] prt_top = prt + AW'(L - 1);
  wire          row_end = prt_top >= last_q;
  wire          fin     = row_end && (anc + AW'(1) >= last_q);

  always_comb begin
    ra[0] = anc;
    for (int k = 1; k < PORTS; k++) ra[k] = prt + AW'(k - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      anc    <= '0;
      prt    <= '0;
      last_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        anc    <= '0;
        prt    <= AW'(1);
        last_q <= AW'(cfg_last);
      end
    end else if (fin) begin
      busy <= 1'b0;
    end else if (row_end) begin
      anc <= anc + AW'(1);
      prt <= anc + AW'(2);
    end else begin
      prt <= prt + AW'(L);
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [31:0] mem [6][DEPTH];
    logic [31:0] qa [6];
    logic [31:0] qb [6];
    always_ff @(posedge clk) begin
      for (int c = 0; c < 6; c++) begin
        if (wr_ok) mem[c][wr_idx] <= wr_w[c];
        qa[c] <= mem[c][ra[2*b][IDX_W-1:0]];
        qb[c] <= mem[c][ra[2*b+1][IDX_W-1:0]];
      end
    end
    for (genvar c = 0; c < 6; c++) begin : g_coord
      assign rq[c][2*b]   = qa[c];
      assign rq[c][2*b+1] = qb[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_act  <= 1'b0;
      s1_last <= 1'b0;
      s1_anc  <= '0;
      s1_prt  <= '0;
    end else begin
      s1_act  <= busy;
      s1_last <= busy && fin;
      s1_anc  <= anc;
      s1_prt  <= prt;
    end
  end

  logic [L-1:0]       nxt_vld, nxt_hit;
  logic [L*IDX_W-1:0] nxt_pid;

  for (genvar k = 0; k < L; k++) begin : g_lane
    wire [AW-1:0] pj = s1_prt + AW'(k);
    logic [2:0] ax_ok;
    for (genvar a = 0; a < 3; a++) begin : g_axis
      assign ax_ok[a] = (ord_key(rq[2*a+1][0]) >= ord_key(rq[2*a][k+1])) &&
                        (ord_key(rq[2*a][0])   <= ord_key(rq[2*a+1][k+1]));
    end
    assign nxt_vld[k] = s1_act && (pj <= last_q);
    assign nxt_hit[k] = nxt_vld[k] && (&ax_ok);
    assign nxt_pid[k*IDX_W +: IDX_W] = pj[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lane_vld    <= '0;
      lane_hit    <= '0;
      done        <= 1'b0;
      anchor_idx  <= '0;
      partner_idx <= '0;
    end else begin
      lane_vld    <= nxt_vld;
      lane_hit    <= nxt_hit;
      done        <= s1_last;
      anchor_idx  <= s1_anc[IDX_W-1:0];
      partner_idx <= nxt_pid;
    end
  end
endmodule

module box_pair_sweep_chk #(
  parameter int BANKS = 2,
  parameter int IDX_W = 5,
  localparam int L = 2 * BANKS - 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               done,
  input logic [L-1:0]       lane_vld,
  input logic [L-1:0]       lane_hit,
  input logic [IDX_W-1:0]   anchor_idx,
  input logic [L*IDX_W-1:0] partner_idx
);
  for (genvar k = 0; k < L; k++) begin : g_chk
    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      lane_hit[k] |-> lane_vld[k]); // R10
    AST_PARTNER_ABOVE_ANCHOR: assert property (@(posedge clk) disable iff (!rst_n)
      lane_vld[k] |-> (partner_idx[k*IDX_W +: IDX_W] > anchor_idx)); // R2
    if (k < L - 1) begin : g_step
      AST_LANE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        lane_vld[k+1] |-> (lane_vld[k] &&
          partner_idx[(k+1)*IDX_W +: IDX_W] == partner_idx[k*IDX_W +: IDX_W] + IDX_W'(1))); // R3
    end
  end
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |=> done); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && !$past(busy, 2)) |-> (lane_vld == '0)); // R7
endmodule

bind box_pair_sweep box_pair_sweep_chk #(.BANKS(BANKS), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_box_pair_sweep.sv
module tb_box_pair_sweep;
  localparam int CLK_PERIOD = 10;
  localparam int BANKS = 2;
  localparam int IDX_W = 5;
  localparam int L = 2 * BANKS - 1;
  localparam int NB = 1 << IDX_W;

  logic clk = 0, rst_n = 0, wr_en = 0, start = 0;
  logic [IDX_W-1:0] wr_idx = '0, cfg_last = '0;
  logic [31:0] wr_xlo = 0, wr_xhi = 0, wr_ylo = 0, wr_yhi = 0, wr_zlo = 0, wr_zhi = 0;
  logic busy, done;
  logic [IDX_W-1:0] anchor_idx;
  logic [L*IDX_W-1:0] partner_idx;
  logic [L-1:0] lane_vld, lane_hit;

  box_pair_sweep #(.BANKS(BANKS), .IDX_W(IDX_W)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  int ref_c [NB][6];
  int vis [NB][NB];
  bit hit_seen [NB][NB];
  int first_a, stray_hit;
  int first_p [L];
  bit first_seen;
  int any_vld;
  logic [31:0] lfsr = 32'h1234_5678;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] f32(input int v);
    logic [31:0] u;
    logic [31:0] m;
    int e;
    if (v == 0) return 32'h0;
    u = (v < 0) ? 32'(-v) : 32'(v);
    e = 0;
    for (int b = 0; b < 24; b++) if (u[b]) e = b;
    m = u << (23 - e);
    return {v < 0, 8'(127 + e), m[22:0]};
  endfunction

  function automatic bit ref_hit(input int i, input int j);
    for (int a = 0; a < 3; a++)
      if (!(ref_c[i][2*a+1] >= ref_c[j][2*a] && ref_c[i][2*a] <= ref_c[j][2*a+1])) return 0;
    return 1;
  endfunction

  function automatic logic [31:0] enc(input int v, input bit nz);
    if (v == 0 && nz) return 32'h8000_0000;
    return f32(v);
  endfunction

  task automatic put_box(input int idx, input int xl, input int xh, input int yl,
                         input int yh, input int zl, input int zh, input bit nz);
    ref_c[idx][0] = xl; ref_c[idx][1] = xh; ref_c[idx][2] = yl;
    ref_c[idx][3] = yh; ref_c[idx][4] = zl; ref_c[idx][5] = zh;
    @(negedge clk);
    wr_en = 1; wr_idx = IDX_W'(idx);
    wr_xlo = enc(xl, nz); wr_xhi = enc(xh, nz); wr_ylo = enc(yl, nz);
    wr_yhi = enc(yh, nz); wr_zlo = enc(zl, nz); wr_zhi = enc(zh, nz);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic sweep(input int last, input bit inject, output int ndone);
    for (int i = 0; i < NB; i++)
      for (int j = 0; j < NB; j++) begin vis[i][j] = 0; hit_seen[i][j] = 0; end
    first_seen = 0; ndone = 0; stray_hit = 0; any_vld = 0;
    @(negedge clk);
    cfg_last = IDX_W'(last); start = 1;
    @(negedge clk);
    start = 0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      for (int k = 0; k < L; k++) begin
        if (lane_vld[k]) begin
          int a, p;
          a = int'(anchor_idx);
          p = int'(partner_idx[k*IDX_W +: IDX_W]);
          vis[a][p]++;
          any_vld++;
          if (lane_hit[k]) hit_seen[a][p] = 1;
          if (!first_seen) begin first_a = a; first_p[k] = p; end
        end else if (lane_hit[k]) stray_hit++;
      end
      if (lane_vld != 0) first_seen = 1;
      if (done) begin ndone++; break; end
      if (inject && cyc == 1) begin
        start = 1; cfg_last = '0;
        wr_en = 1; wr_idx = '0;
        wr_xlo = f32(900); wr_xhi = f32(950); wr_ylo = f32(900);
        wr_yhi = f32(950); wr_zlo = f32(900); wr_zhi = f32(950);
      end else begin
        start = 0; wr_en = 0;
      end
      @(negedge clk);
    end
    start = 0; wr_en = 0;
    @(negedge clk);
    check(done == 0, "R7", "done width one cycle", int'(done), 0);
    check(busy == 0, "R7", "busy low after done", int'(busy), 0);
    check(stray_hit == 0, "R10", "hit on invalid lane", stray_hit, 0);
  endtask

  task automatic verify(input int last, input string tag);
    int bad_v, bad_h, nh;
    bad_v = 0; bad_h = 0; nh = 0;
    for (int i = 0; i < NB; i++)
      for (int j = 0; j < NB; j++) begin
        int ev;
        ev = (i < j && j <= last) ? 1 : 0;
        if (vis[i][j] != ev) bad_v++;
        if (ev == 1) begin
          if (hit_seen[i][j] != ref_hit(i, j)) bad_h++;
        end
      end
    check(bad_v == 0, "R2", {tag, " pairs visited once"}, bad_v, 0);
    check(bad_h == 0, "R5", {tag, " hit flags"}, bad_h, 0);
  endtask

  task automatic t_reset;
    check(busy == 0, "R11", "busy after reset", int'(busy), 0);
    check(done == 0, "R11", "done after reset", int'(done), 0);
    check(lane_vld == 0, "R11", "valid after reset", int'(lane_vld), 0);
    check(lane_hit == 0, "R11", "hit after reset", int'(lane_hit), 0);
  endtask

  task automatic t_all_overlap;
    int nd, nh;
    for (int i = 0; i <= 10; i++) put_box(i, 0, 10, -5, 5, 2, 8, 0);
    sweep(10, 0, nd);
    verify(10, "all-overlap");
    check(nd == 1, "R7", "done count", nd, 1);
    check(first_a == 0, "R3", "first anchor", first_a, 0);
    for (int k = 0; k < L; k++) check(first_p[k] == k + 1, "R3", "first row partner", first_p[k], k + 1);
    nh = 0;
    for (int i = 0; i < NB; i++) for (int j = 0; j < NB; j++) nh += hit_seen[i][j];
    check(nh == 55, "R1", "hit total", nh, 55);
    check(any_vld == 55, "R4", "valid lanes total", any_vld, 55);
  endtask

  task automatic t_chain;
    int nd;
    for (int i = 0; i <= 12; i++) put_box(i, i * 10, i * 10 + 10, 0, 4, 0, 4, 0);
    sweep(12, 0, nd);
    verify(12, "chain");
    check(hit_seen[3][4] == 1, "R5", "touching faces hit", int'(hit_seen[3][4]), 1);
    check(hit_seen[3][5] == 0, "R1", "non-neighbour miss", int'(hit_seen[3][5]), 0);
  endtask

  task automatic t_signs;
    int nd;
    put_box(0, -30, 0, -1, 1, -1, 1, 0);
    put_box(1, 0, 20, -1, 1, -1, 1, 1);
    put_box(2, -50, -20, -1, 1, -1, 1, 0);
    put_box(3, -15, -2, -1, 1, -1, 1, 0);
    put_box(4, -19, 40, -3, -2, -1, 1, 0);
    sweep(4, 0, nd);
    verify(4, "signs");
    check(hit_seen[0][1] == 1, "R6", "+0 meets -0", int'(hit_seen[0][1]), 1);
    check(hit_seen[2][3] == 0, "R6", "negative order miss", int'(hit_seen[2][3]), 0);
    check(hit_seen[2][4] == 0, "R6", "y axis separated", int'(hit_seen[2][4]), 0);
  endtask

  task automatic t_small;
    int nd;
    sweep(0, 0, nd);
    check(nd == 1, "R9", "done with last 0", nd, 1);
    check(any_vld == 0, "R9", "no valid lanes", any_vld, 0);
    sweep(1, 0, nd);
    verify(1, "last1");
    check(any_vld == 1, "R4", "single pair only", any_vld, 1);
  endtask

  task automatic t_busy_ignore;
    int nd;
    for (int i = 0; i <= 12; i++) put_box(i, 0, 10, 0, 10, 0, 10, 0);
    sweep(12, 1, nd);
    check(nd == 1, "R8", "one done despite start", nd, 1);
    verify(12, "busy-start");
    sweep(12, 0, nd);
    verify(12, "after busy write");
    check(hit_seen[0][5] == 1, "R8", "box 0 unchanged", int'(hit_seen[0][5]), 1);
  endtask

  task automatic t_random;
    int nd;
    for (int i = 0; i < NB; i++) begin
      int c [6];
      for (int a = 0; a < 3; a++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        c[2*a] = int'(lfsr[7:0]) - 128;
        c[2*a+1] = c[2*a] + int'(lfsr[13:8]) % 50;
      end
      put_box(i, c[0], c[1], c[2], c[3], c[4], c[5], 0);
    end
    sweep(NB - 1, 0, nd);
    verify(NB - 1, "random");
    check(nd == 1, "R7", "random done count", nd, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_all_overlap();
    t_chain();
    t_signs();
    t_small();
    t_busy_ignore();
    t_random();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule